// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes the byte stream produced by a serial receiver and places it into memory buffers described by a ring of receive descriptors. Each descriptor names a buffer address and carries ownership and status bits. The engine fetches the descriptor at its descriptor pointer. If software has marked that descriptor empty, the engine opens the buffer and writes each incoming byte through a simple memory write port at the next address.

A buffer is closed for one of three reasons: its byte budget is used up, the receiver flags an error, or the frame ends. On close, the engine writes the byte count and status back into the descriptor and hands the descriptor to software by clearing its empty bit. It then steps to the next descriptor, or returns to the ring base after an entry marked as the last of the table.

The byte budget is a programmable maximum length. It is sampled only when a buffer opens, so a change made while a buffer is filling takes effect on the following buffer. Software prepares descriptors through a table write port and inspects them through a registered read port. The ring base, the maximum length, the descriptor pointer and the enable are set through a small register port.

Top module: `rxbd_ring_engine`

## Requirements
- R1: No buffer receives more bytes than the maximum length latched when it opened. When that count is reached, the buffer closes with last=0, err=0 and length equal to the maximum.
- R2: A byte presented with in_eof (and without in_err) is written, and the buffer closes with last=1 and length equal to the bytes written to it.
- R3: A byte presented with in_err is not written. The buffer closes with err=1 and length equal to the bytes written before it.
- R4: Bytes of one buffer go to consecutive addresses starting at the descriptor's buffer address. mem_we, mem_addr and mem_wdata appear one cycle after the byte is accepted.
- R5: After a close, the descriptor pointer (cur_idx) steps by one, or reloads the ring base if the closed descriptor had wrap set. After reset, the first enable starts at the ring base.
- R6: A write to the maximum length while a buffer is open does not change that buffer's limit. It applies from the next descriptor opened.
- R7: cfg_err is high while the maximum length is zero, or is odd with the wide-character bit set. No buffer opens while cfg_err is high. cfg_err is high after reset, because the maximum resets to zero.
- R8: A descriptor pointer write (cfg_sel=2) takes effect only while the engine is disabled or stalled on a non-empty descriptor. It is ignored while a buffer is open.
- R9: On a descriptor whose empty bit is clear, the engine raises rx_busy and opens no buffer. It polls again and opens once software sets the empty bit.
- R10: The descriptor is 36 bits: bit 35 empty, bit 34 wrap, bit 33 last, bit 32 err, bits 31:16 length, bits 15:0 buffer address. On close, the engine writes the length, last and err, clears empty, and keeps wrap and the buffer address.
- R11: A byte presented while no buffer is open causes no memory write.
- R12: After reset: rx_open=0, rx_busy=0, mem_we=0, cur_idx=0.
- R13: Register selects: 0 sets the ring base, 1 sets the maximum length, 2 sets the descriptor pointer, and 3 is control (bit 0 enable, bit 1 wide characters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| bd_we | input | 1 | Descriptor table write strobe |
| bd_widx | input | IDX_W | Descriptor table write index |
| bd_wdata | input | 36 | Descriptor write data |
| bd_ridx | input | IDX_W | Descriptor table read index |
| bd_rdata | output | 36 | Descriptor read data, one cycle after index |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Byte ends the frame |
| in_err | input | 1 | Receive error on this strobe |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer memory address |
| mem_wdata | output | 8 | Buffer memory data |
| rx_open | output | 1 | A buffer is open and accepts bytes |
| rx_busy | output | 1 | Stalled on a descriptor that software still owns |
| cfg_err | output | 1 | Maximum length is invalid |
| cur_idx | output | IDX_W | Descriptor pointer |

## Verification
A byte accepted at a rising edge shows up on the memory write port right after that edge. The bench queues the expected address and data when it drives the byte, and pops the queue at the next falling edge. The descriptor write-back lands one edge after the closing byte, and the next buffer opens three edges after that. The bench therefore waits for rx_open at a falling edge before every byte, and reads descriptors back only once the next buffer is open or the engine has stalled. Register effects are sampled at the falling edge after the write strobe's edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int DESC_W = 4 + LEN_W + ADDR_W;

  typedef struct packed {
    logic              empty;
    logic              wrap;
    logic              last;
    logic              err;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] buf_addr;
  } rx_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_OPEN,
    ST_CLOSE
  } eng_st_t;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_MAX  = 2'd1;
  localparam logic [1:0] SEL_PTR  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
  import rxr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [LEN_W-1:0] cfg_wdata,
  output logic [IDX_W-1:0] base_q,
  output logic [LEN_W-1:0] max_q,
  output logic             enable_q,
  output logic             wide_q,
  output logic             bad_q,
  output logic             ptr_wr,
  output logic [IDX_W-1:0] ptr_val
);
  logic [LEN_W-1:0] nxt_max;
  logic             nxt_wide;

  always_comb begin
    nxt_max  = max_q;
    nxt_wide = wide_q;
    if (cfg_we && cfg_sel == SEL_MAX)  nxt_max  = cfg_wdata;
    if (cfg_we && cfg_sel == SEL_CTRL) nxt_wide = cfg_wdata[1];
  end

  assign ptr_wr  = cfg_we && (cfg_sel == SEL_PTR);
  assign ptr_val = cfg_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      max_q    <= '0;
      enable_q <= 1'b0;
      wide_q   <= 1'b0;
      bad_q    <= 1'b1;
    end else begin
      if (cfg_we && cfg_sel == SEL_BASE) base_q <= cfg_wdata[IDX_W-1:0];
      if (cfg_we && cfg_sel == SEL_CTRL) enable_q <= cfg_wdata[0];
      max_q  <= nxt_max;
      wide_q <= nxt_wide;
      bad_q  <= (nxt_max == '0) || (nxt_wide && nxt_max[0]);
    end
  end

  // R7
  zero_len_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_MAX && cfg_wdata == '0) |=> bad_q);
endmodule

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram
  import rxr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_widx,
  input  rx_desc_t         sw_wdata,
  input  logic [IDX_W-1:0] sw_ridx,
  output rx_desc_t         sw_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  rx_desc_t         eng_wdata,
  input  logic [IDX_W-1:0] eng_ridx,
  output rx_desc_t         eng_rdata
);
  localparam int DEPTH = 1 << IDX_W;

  rx_desc_t table_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (eng_we) table_mem[eng_widx] <= eng_wdata;
    else if (sw_we) table_mem[sw_widx] <= sw_wdata;
    eng_rdata <= table_mem[eng_ridx];
    sw_rdata  <= table_mem[sw_ridx];
  end

  // R10
  handback_clears_empty_chk: assert property (@(posedge clk)
    eng_we |-> !eng_wdata.empty);
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_max,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] in_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              last_slot,
  output logic [LEN_W-1:0]  used
);
  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  lim_q;

  assign last_slot = (cnt_q == LEN_W'(1));
  assign used      = lim_q - cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      lim_q     <= '0;
    end else begin
      mem_we <= wr_fire;
      if (wr_fire) begin
        mem_addr  <= ptr_q;
        mem_wdata <= in_data;
        ptr_q     <= ptr_q + ADDR_W'(1);
        cnt_q     <= cnt_q - LEN_W'(1);
      end
      if (load) begin
        ptr_q <= load_addr;
        cnt_q <= load_max;
        lim_q <= load_max;
      end
    end
  end

  // R1
  budget_left_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> cnt_q != '0);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R6
  limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> $stable(lim_q));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_bad,
  input  logic [IDX_W-1:0]  base,
  input  logic              ptr_wr,
  input  logic [IDX_W-1:0]  ptr_val,
  input  logic              in_valid,
  input  logic              in_eof,
  input  logic              in_err,
  input  rx_desc_t          rd_desc,
  input  logic              last_slot,
  input  logic [LEN_W-1:0]  used,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wb_we,
  output rx_desc_t          wb_desc,
  output logic              load,
  output logic [ADDR_W-1:0] load_addr,
  output logic              wr_fire,
  output logic              open_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  dptr_q
);
  eng_st_t           st;
  logic              fresh_q;
  logic              wrap_q;
  logic [ADDR_W-1:0] addr_q;
  logic              eof_q;
  logic              err_q;
  logic              ptr_ok;
  logic              close_now;
  logic              unused_desc_bits;

  assign unused_desc_bits = ^{rd_desc.last, rd_desc.err, rd_desc.len};

  assign rd_idx    = dptr_q;
  assign open_o    = (st == ST_OPEN);
  assign wr_fire   = (st == ST_OPEN) && enable && in_valid && !in_err;
  assign close_now = (st == ST_OPEN) && enable && in_valid &&
                     (in_err || in_eof || last_slot);
  assign load      = (st == ST_CHECK) && enable && rd_desc.empty && !cfg_bad;
  assign load_addr = rd_desc.buf_addr;
  assign ptr_ok    = (st == ST_IDLE) || busy_o;

  always_comb begin
    wb_we            = (st == ST_CLOSE);
    wb_desc.empty    = 1'b0;
    wb_desc.wrap     = wrap_q;
    wb_desc.last     = eof_q;
    wb_desc.err      = err_q;
    wb_desc.len      = used;
    wb_desc.buf_addr = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      dptr_q  <= '0;
      fresh_q <= 1'b1;
      busy_o  <= 1'b0;
      wrap_q  <= 1'b0;
      addr_q  <= '0;
      eof_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (enable) begin
            st <= ST_FETCH;
            if (fresh_q) dptr_q <= base;
            fresh_q <= 1'b0;
          end
        end
        ST_FETCH: st <= ST_CHECK;
        ST_CHECK: begin
          if (load) begin
            st     <= ST_OPEN;
            wrap_q <= rd_desc.wrap;
            addr_q <= rd_desc.buf_addr;
            busy_o <= 1'b0;
          end else begin
            st     <= ST_FETCH;
            busy_o <= !rd_desc.empty;
          end
        end
        ST_OPEN: begin
          if (close_now) begin
            st    <= ST_CLOSE;
            eof_q <= in_eof;
            err_q <= in_err;
          end
        end
        ST_CLOSE: begin
          st     <= ST_FETCH;
          dptr_q <= wrap_q ? base : dptr_q + IDX_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
      if (!enable && st != ST_IDLE) begin
        st     <= ST_IDLE;
        busy_o <= 1'b0;
      end
      if (ptr_wr && ptr_ok) begin
        dptr_q  <= ptr_val;
        fresh_q <= 1'b0;
        if (st != ST_IDLE && enable) st <= ST_FETCH;
      end
    end
  end

  // R8
  ptr_hold_open_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OPEN) |=> $stable(dptr_q));

  // R5
  wrap_base_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLOSE && wrap_q) |=> (dptr_q == $past(base)));

  // R5
  step_next_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLOSE && !wrap_q) |=> (dptr_q == $past(dptr_q) + IDX_W'(1)));

  // R9
  busy_not_open_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !open_o);

  // R7
  bad_cfg_no_open_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && cfg_bad) |=> !open_o);
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [LEN_W-1:0]  cfg_wdata,
  input  logic              bd_we,
  input  logic [IDX_W-1:0]  bd_widx,
  input  logic [DESC_W-1:0] bd_wdata,
  input  logic [IDX_W-1:0]  bd_ridx,
  output logic [DESC_W-1:0] bd_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic              in_err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rx_open,
  output logic              rx_busy,
  output logic              cfg_err,
  output logic [IDX_W-1:0]  cur_idx
);
  logic [IDX_W-1:0]  base_q;
  logic [LEN_W-1:0]  max_q;
  logic              enable_q;
  logic              wide_q;
  logic              ptr_wr;
  logic [IDX_W-1:0]  ptr_val;
  rx_desc_t          sw_wdesc;
  rx_desc_t          sw_rdesc;
  rx_desc_t          eng_rdesc;
  rx_desc_t          wb_desc;
  logic              wb_we;
  logic [IDX_W-1:0]  rd_idx;
  logic              load;
  logic [ADDR_W-1:0] load_addr;
  logic              wr_fire;
  logic              last_slot;
  logic [LEN_W-1:0]  used;
  logic              unused_wide;

  assign sw_wdesc    = rx_desc_t'(bd_wdata);
  assign bd_rdata    = sw_rdesc;
  assign unused_wide = wide_q;

  rxr_cfg_regs #(.IDX_W(IDX_W)) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .max_q(max_q), .enable_q(enable_q), .wide_q(wide_q),
    .bad_q(cfg_err), .ptr_wr(ptr_wr), .ptr_val(ptr_val)
  );

  rxr_desc_ram #(.IDX_W(IDX_W)) i_ram (
    .clk(clk),
    .sw_we(bd_we), .sw_widx(bd_widx), .sw_wdata(sw_wdesc),
    .sw_ridx(bd_ridx), .sw_rdata(sw_rdesc),
    .eng_we(wb_we), .eng_widx(cur_idx), .eng_wdata(wb_desc),
    .eng_ridx(rd_idx), .eng_rdata(eng_rdesc)
  );

  rxr_fill i_fill (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .load_max(max_q),
    .wr_fire(wr_fire), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .last_slot(last_slot), .used(used)
  );

  rxr_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rst(rst), .enable(enable_q), .cfg_bad(cfg_err), .base(base_q),
    .ptr_wr(ptr_wr), .ptr_val(ptr_val),
    .in_valid(in_valid), .in_eof(in_eof), .in_err(in_err),
    .rd_desc(eng_rdesc), .last_slot(last_slot), .used(used),
    .rd_idx(rd_idx), .wb_we(wb_we), .wb_desc(wb_desc),
    .load(load), .load_addr(load_addr), .wr_fire(wr_fire),
    .open_o(rx_open), .busy_o(rx_busy), .dptr_q(cur_idx)
  );

  // R11
  write_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(rx_open && in_valid && !in_err));
endmodule

// File: tb/test_rxbd_ring_engine.sv
module test_rxbd_ring_engine;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        bd_we = 1'b0;
  logic [IW-1:0] bd_widx = '0;
  logic [35:0] bd_wdata = '0;
  logic [IW-1:0] bd_ridx = '0;
  logic [35:0] bd_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_eof = 1'b0;
  logic        in_err = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rx_open, rx_busy, cfg_err;
  logic [IW-1:0] cur_idx;

  always #5 clk = ~clk;

  rxbd_ring_engine #(.IDX_W(IW)) i_rxbd_ring_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bd_we(bd_we), .bd_widx(bd_widx), .bd_wdata(bd_wdata),
    .bd_ridx(bd_ridx), .bd_rdata(bd_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof), .in_err(in_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_open(rx_open), .rx_busy(rx_busy), .cfg_err(cfg_err), .cur_idx(cur_idx)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_wr  = 0;

  int exp_a[$];
  int exp_d[$];
  int m_idx = 0, m_base = 0, m_max_cfg = 0, m_max = 0, m_cnt = 0, m_ptr = 0;
  bit m_live = 0;
  int bd_addr [16];
  bit bd_wrap [16];
  int exp_len [16];
  bit exp_last[16];
  bit exp_err [16];

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      n_wr++;
      if (exp_a.size() == 0) begin
        chk_eq("R11 write with no byte expected", 1, 0);
      end else begin
        int a;
        int d;
        a = exp_a.pop_front();
        d = exp_d.pop_front();
        chk_eq("R4 write address", mem_addr, a);
        chk_eq("R4 write data", mem_wdata, d);
      end
    end
  end

  task automatic cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = val[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bd_put(input int idx, input bit empty, input bit wrap, input int addr);
    @(negedge clk);
    bd_we = 1'b1; bd_widx = idx[IW-1:0];
    bd_wdata = {empty, wrap, 2'b00, 16'h0000, addr[15:0]};
    bd_addr[idx] = addr; bd_wrap[idx] = wrap;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_open(input string tag);
    int k;
    k = 0;
    while (!rx_open && k < 60) begin
      @(negedge clk);
      k++;
    end
    if (!rx_open) chk_eq(tag, 0, 1);
  endtask

  task automatic send(input int d, input bit eof, input bit err);
    wait_open("R9 buffer expected open");
    if (!m_live) begin
      m_live = 1; m_max = m_max_cfg; m_cnt = 0; m_ptr = bd_addr[m_idx];
    end
    in_valid = 1'b1; in_data = d[7:0]; in_eof = eof; in_err = err;
    if (!err) begin
      exp_a.push_back(m_ptr); exp_d.push_back(d);
      m_ptr++; m_cnt++;
    end
    if (err || eof || m_cnt == m_max) begin
      exp_len[m_idx] = m_cnt; exp_last[m_idx] = eof; exp_err[m_idx] = err;
      m_live = 0;
      m_idx = bd_wrap[m_idx] ? m_base : (m_idx + 1) % 16;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  task automatic check_bd(input int idx, input string tag);
    logic [35:0] d;
    @(negedge clk);
    bd_ridx = idx[IW-1:0];
    @(negedge clk);
    d = bd_rdata;
    chk_eq({tag, " R10 empty cleared"}, d[35], 0);
    chk_eq({tag, " R10 wrap kept"}, d[34], bd_wrap[idx]);
    chk_eq({tag, " R2 last"}, d[33], exp_last[idx]);
    chk_eq({tag, " R3 err"}, d[32], exp_err[idx]);
    chk_eq({tag, " R1 length"}, d[31:16], exp_len[idx]);
    chk_eq({tag, " R10 address kept"}, d[15:0], bd_addr[idx]);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk_eq("R12 rx_open", rx_open, 0);
    chk_eq("R12 rx_busy", rx_busy, 0);
    chk_eq("R12 mem_we", mem_we, 0);
    chk_eq("R12 cur_idx", cur_idx, 0);
    chk_eq("R7 cfg_err at reset", cfg_err, 1);

    for (int i = 0; i < 16; i++) bd_put(i, 0, 0, 0);
    bd_put(2, 1, 0, 'h0100);
    bd_put(3, 1, 0, 'h0200);
    bd_put(4, 1, 1, 'h0300);
    bd_put(5, 1, 1, 'h0500);

    // R13 register selects
    cfg(1, 4); m_max_cfg = 4;
    chk_eq("R7 cfg_err cleared", cfg_err, 0);
    cfg(0, 2); m_base = 2;
    cfg(3, 1); m_idx = 2;
    wait_open("R5 first open");
    chk_eq("R5 starts at base", cur_idx, 2);

    // R6: limit change mid buffer
    send('h11, 0, 0);
    cfg(1, 3); m_max_cfg = 3;
    send('h12, 0, 0);
    send('h13, 0, 0);
    send('h14, 0, 0);
    // R2: frame end in next buffer
    send('h21, 0, 0);
    send('h22, 1, 0);
    // R3: error in third buffer
    send('h31, 0, 0);
    send('h32, 0, 0);
    send('h33, 0, 1);
    idle(8);
    // R9 stall on owned descriptor after wrap
    chk_eq("R9 rx_busy", rx_busy, 1);
    chk_eq("R9 rx_open low", rx_open, 0);
    chk_eq("R5 wrapped to base", cur_idx, 2);
    check_bd(2, "bd2 R6");
    check_bd(3, "bd3");
    check_bd(4, "bd4");

    // R11: byte while nothing open
    w0 = n_wr;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    idle(3);
    chk_eq("R11 no write while stalled", n_wr, w0);

    // R8: pointer write accepted while stalled
    cfg(2, 5); m_idx = 5;
    wait_open("R8 open after pointer write");
    chk_eq("R8 pointer taken", cur_idx, 5);
    chk_eq("R9 busy cleared", rx_busy, 0);
    cfg(2, 3);
    chk_eq("R8 pointer ignored while open", cur_idx, 5);
    send('h51, 0, 0);
    send('h52, 0, 0);
    send('h53, 0, 0);
    idle(8);
    chk_eq("R5 wrap from 5 to base", cur_idx, 2);
    check_bd(5, "bd5 R1");

    // R7: invalid limits
    cfg(3, 3);
    cfg(1, 3);
    chk_eq("R7 odd with wide", cfg_err, 1);
    bd_put(2, 1, 0, 'h0100);
    idle(10);
    chk_eq("R7 no open while invalid", rx_open, 0);
    cfg(1, 0);
    chk_eq("R7 zero limit", cfg_err, 1);
    cfg(1, 4); m_max_cfg = 4;
    chk_eq("R7 even with wide", cfg_err, 0);
    wait_open("R7 open after fix");
    chk_eq("R5 index after fix", cur_idx, 2);
    send('h61, 0, 0);
    send('h62, 0, 0);
    send('h63, 0, 0);
    send('h64, 0, 0);
    idle(8);
    check_bd(2, "bd2 second R1");
    chk_eq("R9 stalled on bd3", rx_busy, 1);
    chk_eq("R4 all writes seen", exp_a.size(), 0);

    summary();
    $finish;
  end
endmodule